// File: doc/BRIEF.md
# Serial Configuration Loader with Addressed Latches

This block takes configuration words over a three-wire serial port: a data line, a serial clock and a load strobe. Each serial-clock rising edge shifts one data bit into a 24-bit shift register, most significant bit first. When the load strobe rises, the upper 22 bits of the word are copied into one of four configuration latches. The two bits shifted in last select which latch. The serial inputs are asynchronous to the system clock, so each one passes through a synchroniser, and every action takes place on an edge detected in the system clock domain.

Latch 0 holds two control fields. A power-down bit and the chip-enable input together decide whether the charge-pump enable output is driven or the tri-state flag is raised. A two-bit select field chooses what appears on the status output: a constant low, lock detect, a scaled RF indication or a scaled reference indication. Chip enable has no effect on the serial port, so the latches can be programmed before power-up.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset all four latches read zero on `cfg_q`.
- R2: A word is shifted in MSB first, one bit per rising edge of `sclk`. Each `sclk` high and low phase lasts at least 3 `clk` cycles. The latch receives word bits 23:2, and word bit 23 maps to latch bit 21.
- R3: A latch changes only after a rising edge of `sload`. Shifting with `sload` low changes no latch, and holding `sload` high causes no second load.
- R4: Word bits 1:0 form an address, and the values 0 to 3 select latch 0 to latch 3. Latch k appears on `cfg_q[22*k+21:22*k]`. A load leaves the other three latches unchanged.
- R5: A load does not clear the shift register. If only n new bits are shifted before the next load, that load takes the previous word moved left by n with the new bits below it.
- R6: While `chip_en` is low, `cp_enable` is 0 and `cp_hiz` is 1.
- R7: While `chip_en` is high, `cp_enable` is the inverse of latch 0 bit 0 (word bit 2), and `cp_hiz` is always the inverse of `cp_enable`.
- R8: Latch 0 bits 2:1 (word bits 4:3) select `stat_out`. The value 0 gives low, 1 gives `lock_det`, 2 gives `rf_scaled` and 3 gives `ref_scaled`.
- R9: Shifting and loading work the same way while `chip_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first |
| sload | input | 1 | Load strobe, acts on its rising edge |
| chip_en | input | 1 | Chip enable, low forces power-down |
| lock_det | input | 1 | Lock detect indication |
| rf_scaled | input | 1 | Scaled RF indication |
| ref_scaled | input | 1 | Scaled reference indication |
| cp_enable | output | 1 | Charge-pump enable |
| cp_hiz | output | 1 | Charge-pump tri-state flag |
| stat_out | output | 1 | Multiplexed status output |
| cfg_q | output | 88 | The four latches, latch k in bits 22k+21:22k |

## Verification
All latch contents appear directly on `cfg_q`. A wrong address decode, a wrong bit order or a spurious load therefore shows on the port within a few system clock cycles of the load edge. A shift register that is wrongly cleared or mis-shifted is hidden until the next load, so the bench uses partial-length shifts to expose it. A fault in the power-down bit or the select field shows at once on `cp_enable`, `cp_hiz` and `stat_out`, and the bench sweeps every select value against every combination of the three status inputs.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int WORD_W      = 24,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PD_BIT      = 0,
  parameter int SEL_LSB     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdata,
  input  logic sload,
  input  logic chip_en,
  input  logic lock_det,
  input  logic rf_scaled,
  input  logic ref_scaled,
  output logic cp_enable,
  output logic cp_hiz,
  output logic stat_out,
  output logic [(2**ADDR_W)*(WORD_W-ADDR_W)-1:0] cfg_q
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int NLAT   = 2**ADDR_W;
  localparam int TOP    = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sy, sdat_sy, load_sy;
  logic sclk_d, load_d;
  logic [WORD_W-1:0] shreg;
  logic [DATA_W-1:0] lat [NLAT];
  logic [1:0] sel;
  logic pd;

  wire sclk_rise  = sclk_sy[TOP] & ~sclk_d;
  wire load_pulse = load_sy[TOP] & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdat_sy <= '0;
      load_sy <= '0;
      sclk_d  <= 1'b0;
      load_d  <= 1'b0;
      shreg   <= '0;
      for (int i = 0; i < NLAT; i++) lat[i] <= '0;
    end else begin
      sclk_sy <= {sclk_sy[TOP-1:0], sclk};
      sdat_sy <= {sdat_sy[TOP-1:0], sdata};
      load_sy <= {load_sy[TOP-1:0], sload};
      sclk_d  <= sclk_sy[TOP];
      load_d  <= load_sy[TOP];
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_sy[TOP]};
      if (load_pulse) lat[shreg[ADDR_W-1:0]] <= shreg[WORD_W-1:ADDR_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NLAT; g++) begin : g_out
      assign cfg_q[g*DATA_W +: DATA_W] = lat[g];
    end
  endgenerate

  assign pd        = lat[0][PD_BIT];
  assign sel       = lat[0][SEL_LSB +: 2];
  assign cp_enable = chip_en & ~pd;
  assign cp_hiz    = ~cp_enable;

  always_comb begin
    case (sel)
      2'd1:    stat_out = lock_det;
      2'd2:    stat_out = rf_scaled;
      2'd3:    stat_out = ref_scaled;
      default: stat_out = 1'b0;
    endcase
  end
endmodule

module serial_cfg_loader_chk #(
  parameter int WORD_W  = 24,
  parameter int ADDR_W  = 2,
  parameter int PD_BIT  = 0,
  parameter int SEL_LSB = 1
) (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic cp_enable,
  input logic cp_hiz,
  input logic stat_out,
  input logic load_pulse,
  input logic [(2**ADDR_W)*(WORD_W-ADDR_W)-1:0] cfg_q
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int NLAT   = 2**ADDR_W;

  logic [NLAT*DATA_W-1:0] prev;
  logic [NLAT-1:0] chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= cfg_q;

  genvar g;
  generate
    for (g = 0; g < NLAT; g++) begin : g_chg
      assign chg[g] = cfg_q[g*DATA_W +: DATA_W] != prev[g*DATA_W +: DATA_W];
    end
  endgenerate

  a_r3_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(cfg_q));
  a_r4_one_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1);
  a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (!cp_enable && cp_hiz));
  a_r7_pd_bit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[PD_BIT] |-> !cp_enable);
  a_r7_hiz_opposes: assert property (@(posedge clk) disable iff (!rst_n)
    cp_hiz != cp_enable);
  a_r8_sel_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[SEL_LSB +: 2] == 2'd0) |-> !stat_out);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .PD_BIT(PD_BIT), .SEL_LSB(SEL_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cp_enable(cp_enable),
  .cp_hiz(cp_hiz), .stat_out(stat_out), .load_pulse(load_pulse), .cfg_q(cfg_q)
);

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, sload = 0, chip_en = 1;
  logic lock_det = 0, rf_scaled = 0, ref_scaled = 0;
  logic cp_enable, cp_hiz, stat_out;
  logic [87:0] cfg_q;

  int checks = 0, errors = 0;
  logic [21:0] mdl [4];
  logic [23:0] msh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader u0 (.*);

  task automatic chk(input string req, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_clk(HALF);
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
      msh = {msh[22:0], w[i]};
    end
    wait_clk(HALF);
  endtask

  task automatic do_load();
    sload = 1;
    wait_clk(HALF);
    sload = 0;
    wait_clk(HALF);
    mdl[msh[1:0]] = msh[23:2];
  endtask

  function automatic logic [87:0] model_q();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic write(input logic [21:0] d, input logic [1:0] a);
    shift_bits({d, a}, 24);
    do_load();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    chk("R1 reset latches", cfg_q, '0);
    chk("R7 enable after reset", {87'd0, cp_enable}, 88'd1);

    // R2/R4: every address with several patterns
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 4; a++) begin
        write(22'((k * 22'h12345 + a * 22'h0ABCD) ^ (22'h3F0F0F >> k)), 2'(a));
        chk("R2/R4 addressed load", cfg_q, model_q());
      end

    // R3: shift without load changes nothing
    shift_bits(24'hA5A5A6, 24);
    chk("R3 no load without strobe", cfg_q, model_q());
    // R3: held-high strobe gives one load only
    sload = 1;
    wait_clk(HALF * 2);
    mdl[msh[1:0]] = msh[23:2];
    chk("R3 load on rise", cfg_q, model_q());
    shift_bits(24'h123457, 24);
    chk("R3 held strobe no reload", cfg_q, model_q());
    sload = 0;
    wait_clk(HALF);

    // R5: partial shifts keep earlier contents
    write(22'h2AAAAA, 2'd3);
    for (int n = 4; n <= 12; n += 4) begin
      shift_bits(24'(n * 5 + 1), n);
      do_load();
      chk("R5 partial shift load", cfg_q, model_q());
    end

    // R9: configuration with chip disabled
    chip_en = 0;
    write(22'h155555, 2'd1);
    chk("R9 load while disabled", cfg_q, model_q());
    chk("R6 hiz while disabled", {86'd0, cp_enable, cp_hiz}, 88'd1);

    // R6/R7: chip enable against power-down bit
    for (int pdv = 0; pdv < 2; pdv++) begin
      write(22'(pdv), 2'd0);
      for (int ce = 0; ce < 2; ce++) begin
        chip_en = 1'(ce);
        wait_clk(1);
        chk(ce ? "R7 enable by pd bit" : "R6 forced off",
            {86'd0, cp_enable, cp_hiz},
            {86'd0, 1'(ce && !pdv), ~1'(ce && !pdv)});
      end
    end

    // R8: every select against every input combination
    for (int s = 0; s < 4; s++) begin
      write(22'(s << 1), 2'd0);
      for (int v = 0; v < 8; v++) begin
        {ref_scaled, rf_scaled, lock_det} = 3'(v);
        wait_clk(1);
        chk("R8 status select", {87'd0, stat_out},
            {87'd0, (s == 0) ? 1'b0 : 1'((v >> (s - 1)) & 1)});
      end
    end
    chk("R4 final latch image", cfg_q, model_q());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule